// File: doc/BRIEF.md
# Trap Entry Controller

This block decides when a small RISC core leaves its normal instruction stream and where it goes. It watches eight level-sensitive interrupt lines and a one-cycle exception strobe from the pipeline. When a trap is accepted, it saves the privilege level, the interrupt enable and the return address. It forces the core to privilege 0 with interrupts off and issues a one-cycle redirect carrying the next fetch address.

There are three save paths. The normal path writes the ordinary save registers. The TLB-refill path is used while a software-visible refill flag is set. The debug path is used for breakpoints and for interrupts that arrive in debug state. Entry addresses are vectored. A programmable spacing multiplies the cause code, or for interrupts the external-interrupt base code plus the line number. A return strobe restores the saved mode and redirects the core to the saved PC. All state is visible through a simple select/data register port.

Top module: `trap_entry_unit`

## Requirements
- R1: Each interrupt line is copied on every clock into its own bit of the pending field, STAT[7:0]. That copy lags the line by one cycle and cannot be written. A request exists only when pending AND the enable mask CFG[7:0] is nonzero.
- R2: A hardware interrupt is accepted only when MODE[2] (global enable) is 1 and DBG[0] (debug state) is 0. An exception strobe or a return strobe in the same cycle takes precedence over it.
- R3: The highest-numbered line that is both pending and enabled wins, and its number is the vector.
- R4: The spacing is 4<<VS bytes when VS = CFG[18:16] is nonzero, and 0 bytes when VS is zero.
- R5: An interrupt enters at BASE + (64 + vector) * spacing; any other normal entry enters at BASE + cause * spacing. redirect_valid pulses for one cycle in the cycle after acceptance, and redirect_pc holds the target until the next redirect. Cause codes:
  - 0 interrupt
  - 1 load page invalid
  - 2 store page invalid
  - 3 fetch page invalid
  - 4 page modified
  - 5 not readable
  - 6 not executable
  - 7 page privilege
  - 8 address error, with sub 0 for fetch and sub 1 for data
  - 9 misaligned
  - 10 bound check
  - 11 syscall
  - 12 break
  - 13 reserved instruction
  - 14 privileged instruction
  - 15 FP disabled
  - 16 128-bit vector disabled
  - 17 256-bit vector disabled
  - 18 FP exception
  - 26 debug breakpoint
- R6: A normal entry with the refill flag clear does three things:
  - writes the cause to STAT[21:16] and the sub-code to STAT[30:22];
  - copies MODE[1:0] and MODE[2] into PMODE[1:0] and PMODE[2];
  - loads RET with core_pc.
- R7: A normal entry with the refill flag RFRET[0] set does four things:
  - saves the privilege and enable into RFPMODE[1:0] and RFPMODE[2] instead of PMODE;
  - stores core_pc[31:2] into RFRET[31:2];
  - sets MODE[3] (direct addressing) to 1 and clears MODE[4] (paging);
  - for non-interrupt causes, jumps to RFBASE.

  RET, STAT and PMODE are left unchanged.
- R8: A breakpoint (cause 26) does four things:
  - sets DBG[0] (debug state) and DBG[2];
  - writes 0xC to DBG[21:16];
  - loads DRET with core_pc;
  - jumps to BASE + 0x480.

  An exception strobe with cause 0 while in debug state sets DBG[1] and takes the same path.
- R9: Every entry forces MODE[1:0] to 0 and MODE[2] to 0.
- R10: BADADDR receives core_pc for causes 11 to 18. BADINSN receives core_insn for every normal entry except interrupts, cause 3, and cause 8 with sub 0.
- R11: After reset:
  - redirect_pc is 0x1C000000 and redirect_valid is 0;
  - MODE reads 0x08, meaning privilege 0, interrupts off, direct addressing on and paging off;
  - CFG reads 0.
- R12: A return strobe restores MODE[1:0] and MODE[2] from PMODE and redirects to RET. While the refill flag is set, it restores from RFPMODE instead, redirects to RFRET[31:2]<<2, and clears the refill flag.
- R13: Register selectors are MODE 0, PMODE 1, CFG 2, STAT 3, RET 4, BADADDR 5, BADINSN 6, BASE 7, RFBASE 8, RFRET 9, RFPMODE 10, DBG 11 and DRET 12. Writes take effect at the clock edge and reads are combinational. A trap in the same cycle wins over a write to the same field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_valid | input | 1 | One-cycle exception request |
| exc_cause | input | 6 | Major cause code |
| exc_sub | input | 9 | Cause sub-code |
| core_pc | input | 32 | PC of the trapping or interrupted instruction |
| core_insn | input | 32 | Instruction word at core_pc |
| irq_lines | input | 8 | Level-sensitive interrupt lines |
| ertn_valid | input | 1 | Return-from-trap strobe |
| csr_we | input | 1 | Register write enable |
| csr_wsel | input | 4 | Register write selector |
| csr_wdata | input | 32 | Register write data |
| csr_rsel | input | 4 | Register read selector |
| csr_rdata | output | 32 | Register read data |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | Next fetch address |
| cur_plv | output | 2 | Current privilege level |
| cur_ie | output | 1 | Current global interrupt enable |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, eight lines and an external-interrupt base code of 64. With these values, every spacing setting from 0 up to 512 bytes yields entry offsets that the bench can compute by hand. Vector 7 at 32-byte spacing lands at 0x8E0 and is clearly separated from the debug entry at 0x480. The eight-line width is also enough to show highest-line priority across widely separated bits.

// File: rtl/trap_pkg.sv
// Shared constants for the trap entry controller: cause codes, register
// selectors and cause classification helpers. Assumes 6-bit cause codes.
package trap_pkg;

    localparam int CAUSE_W = 6;
    localparam int SUB_W   = 9;
    localparam int SEL_W   = 4;

    localparam logic [5:0] CC_IRQ       = 6'd0;
    localparam logic [5:0] CC_LDPAGE    = 6'd1;
    localparam logic [5:0] CC_STPAGE    = 6'd2;
    localparam logic [5:0] CC_FETCHPAGE = 6'd3;
    localparam logic [5:0] CC_MODPAGE   = 6'd4;
    localparam logic [5:0] CC_NOREAD    = 6'd5;
    localparam logic [5:0] CC_NOEXEC    = 6'd6;
    localparam logic [5:0] CC_PRIVPAGE  = 6'd7;
    localparam logic [5:0] CC_ADDRERR   = 6'd8;
    localparam logic [5:0] CC_ALIGN     = 6'd9;
    localparam logic [5:0] CC_BOUND     = 6'd10;
    localparam logic [5:0] CC_SYSCALL   = 6'd11;
    localparam logic [5:0] CC_BREAK     = 6'd12;
    localparam logic [5:0] CC_RESVD     = 6'd13;
    localparam logic [5:0] CC_PRIVINSN  = 6'd14;
    localparam logic [5:0] CC_FPOFF     = 6'd15;
    localparam logic [5:0] CC_VEC128OFF = 6'd16;
    localparam logic [5:0] CC_VEC256OFF = 6'd17;
    localparam logic [5:0] CC_FPEXC     = 6'd18;
    localparam logic [5:0] CC_DEBUG     = 6'd26;

    localparam logic [5:0] DBG_BRK_CODE = 6'hC;

    localparam logic [3:0] SEL_MODE    = 4'd0;
    localparam logic [3:0] SEL_PMODE   = 4'd1;
    localparam logic [3:0] SEL_CFG     = 4'd2;
    localparam logic [3:0] SEL_STAT    = 4'd3;
    localparam logic [3:0] SEL_RET     = 4'd4;
    localparam logic [3:0] SEL_BADADDR = 4'd5;
    localparam logic [3:0] SEL_BADINSN = 4'd6;
    localparam logic [3:0] SEL_BASE    = 4'd7;
    localparam logic [3:0] SEL_RFBASE  = 4'd8;
    localparam logic [3:0] SEL_RFRET   = 4'd9;
    localparam logic [3:0] SEL_RFPMODE = 4'd10;
    localparam logic [3:0] SEL_DBG     = 4'd11;
    localparam logic [3:0] SEL_DRET    = 4'd12;

    // Causes whose entry records the PC as the bad address.
    function automatic logic sets_badaddr(input logic [5:0] c);
        return (c >= CC_SYSCALL) && (c <= CC_FPEXC);
    endfunction

    // Causes for which no instruction word is captured.
    function automatic logic skips_badinsn(input logic [5:0] c, input logic [8:0] sub);
        return (c == CC_IRQ) || (c == CC_FETCHPAGE) ||
               ((c == CC_ADDRERR) && (sub == 9'd0));
    endfunction

endpackage

// File: rtl/trap_irq_pick.sv
// Priority picker: returns the index of the highest-numbered set request bit.
// Assumes NUM_IRQ >= 2. Purely combinational.
module trap_irq_pick #(
    parameter int NUM_IRQ = 8,
    parameter int IDX_W   = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    // Scan upwards so the last (highest) set bit is kept.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // The chosen bit is set and nothing above it is set.
    always_comb begin
        if (any) begin
            p_pick_top_r3: assert ((req >> idx) == NUM_IRQ'(1));
        end
    end

endmodule

// File: rtl/trap_vec_calc.sv
// Vectored entry address: base plus code times a spacing of 4<<vs bytes,
// or plus nothing when vs is zero. Uses a shift in place of a multiplier.
module trap_vec_calc #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 8
) (
    input  logic [XLEN-1:0]   base,
    input  logic [2:0]        vs,
    input  logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   entry
);

    logic [3:0]      shamt;
    logic [XLEN-1:0] offset;

    // Spacing of 4<<vs applied as a left shift of the code by vs+2.
    always_comb begin
        shamt  = {1'b0, vs} + 4'd2;
        offset = (vs == 3'd0) ? '0 : (XLEN'(code) << shamt);
        entry  = base + offset;
    end

    // Offsets are whole words, so the low bits follow the base.
    always_comb begin
        p_word_offset_r4: assert (entry[1:0] == base[1:0]);
    end

endmodule

// File: rtl/trap_entry_unit.sv
// Trap entry controller. Samples interrupt lines, accepts exceptions,
// saves mode and return state on one of three paths (normal, refill,
// debug), computes the next fetch address and handles the return strobe.
// Assumes XLEN = 32 for the register field layout and NUM_IRQ <= 16.
// Synchronous active-low reset.
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter int              NUM_IRQ      = 8,
    parameter int              EXT_INT_BASE = 64,
    parameter logic [XLEN-1:0] RESET_PC     = 'h1C00_0000,
    parameter int              DBG_OFFSET   = 'h480
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_valid,
    input  logic [5:0]         exc_cause,
    input  logic [8:0]         exc_sub,
    input  logic [XLEN-1:0]    core_pc,
    input  logic [31:0]        core_insn,
    input  logic [NUM_IRQ-1:0] irq_lines,
    input  logic               ertn_valid,
    input  logic               csr_we,
    input  logic [3:0]         csr_wsel,
    input  logic [XLEN-1:0]    csr_wdata,
    input  logic [3:0]         csr_rsel,
    output logic [XLEN-1:0]    csr_rdata,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic [1:0]         cur_plv,
    output logic               cur_ie
);

    localparam int IDX_W  = $clog2(NUM_IRQ);
    localparam int CODE_W = $clog2(EXT_INT_BASE + NUM_IRQ) + 1;

    // Architectural state
    logic [1:0]         mode_plv, pm_plv, rfp_plv;
    logic               mode_ie, mode_da, mode_pg, pm_ie, rfp_ie;
    logic [NUM_IRQ-1:0] cfg_lie, st_is;
    logic [2:0]         cfg_vs;
    logic [5:0]         st_ecode, dbg_code;
    logic [8:0]         st_esub;
    logic [XLEN-1:0]    era, badv, badi, base, rfbase, dret;
    logic               rf_flag, dbg_dst, dbg_dei, dbg_dcl;
    logic [XLEN-3:0]    rf_pc;
    logic               redir_v;
    logic [XLEN-1:0]    redir_pc;

    // Decision signals
    logic               irq_any, hw_take, dbg_entry, norm_entry, ent_int;
    logic [IDX_W-1:0]   irq_idx;
    logic [5:0]         ent_cause;
    logic [8:0]         ent_sub;
    logic [CODE_W-1:0]  ent_code;
    logic [XLEN-1:0]    vec_pc, norm_pc, dbg_pc;

    trap_irq_pick #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_pick (
        .req (st_is & cfg_lie),
        .any (irq_any),
        .idx (irq_idx)
    );

    // Select the trap source and its cause for this cycle.
    always_comb begin
        hw_take    = irq_any && mode_ie && !dbg_dst && !exc_valid && !ertn_valid;
        dbg_entry  = exc_valid && ((exc_cause == CC_DEBUG) ||
                                   ((exc_cause == CC_IRQ) && dbg_dst));
        norm_entry = (exc_valid && !dbg_entry) || hw_take;
        ent_cause  = hw_take ? CC_IRQ : exc_cause;
        ent_sub    = hw_take ? 9'd0   : exc_sub;
        ent_int    = (ent_cause == CC_IRQ);
        ent_code   = ent_int ? (CODE_W'(EXT_INT_BASE) + CODE_W'(irq_idx))
                             : CODE_W'(ent_cause);
    end

    trap_vec_calc #(.XLEN(XLEN), .CODE_W(CODE_W)) u_vec (
        .base  (base),
        .vs    (cfg_vs),
        .code  (ent_code),
        .entry (vec_pc)
    );

    // Refill entries for exceptions bypass the vector table.
    always_comb begin
        norm_pc = (rf_flag && !ent_int) ? rfbase : vec_pc;
        dbg_pc  = base + XLEN'(DBG_OFFSET);
    end

    // Register state: reset, line sampling, register writes, then traps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_plv <= '0; mode_ie <= 1'b0; mode_da <= 1'b1; mode_pg <= 1'b0;
            pm_plv   <= '0; pm_ie   <= 1'b0; rfp_plv <= '0;   rfp_ie  <= 1'b0;
            cfg_lie  <= '0; cfg_vs  <= '0;   st_is   <= '0;
            st_ecode <= '0; st_esub <= '0;   dbg_code <= '0;
            era <= '0; badv <= '0; badi <= '0; base <= '0; rfbase <= '0; dret <= '0;
            rf_flag  <= 1'b0; rf_pc <= '0;
            dbg_dst  <= 1'b0; dbg_dei <= 1'b0; dbg_dcl <= 1'b0;
            redir_v  <= 1'b0; redir_pc <= RESET_PC;
        end else begin
            st_is   <= irq_lines;
            redir_v <= 1'b0;
            if (csr_we) begin
                case (csr_wsel)
                    SEL_MODE: begin
                        mode_plv <= csr_wdata[1:0]; mode_ie <= csr_wdata[2];
                        mode_da  <= csr_wdata[3];   mode_pg <= csr_wdata[4];
                    end
                    SEL_PMODE:   begin pm_plv  <= csr_wdata[1:0]; pm_ie  <= csr_wdata[2]; end
                    SEL_RFPMODE: begin rfp_plv <= csr_wdata[1:0]; rfp_ie <= csr_wdata[2]; end
                    SEL_CFG: begin
                        cfg_lie <= csr_wdata[NUM_IRQ-1:0]; cfg_vs <= csr_wdata[18:16];
                    end
                    SEL_STAT: begin
                        st_ecode <= csr_wdata[21:16]; st_esub <= csr_wdata[30:22];
                    end
                    SEL_RET:     era    <= csr_wdata;
                    SEL_BADADDR: badv   <= csr_wdata;
                    SEL_BADINSN: badi   <= csr_wdata;
                    SEL_BASE:    base   <= csr_wdata;
                    SEL_RFBASE:  rfbase <= csr_wdata;
                    SEL_RFRET: begin rf_flag <= csr_wdata[0]; rf_pc <= csr_wdata[XLEN-1:2]; end
                    SEL_DBG: begin
                        dbg_dst <= csr_wdata[0]; dbg_dei <= csr_wdata[1];
                        dbg_dcl <= csr_wdata[2]; dbg_code <= csr_wdata[21:16];
                    end
                    SEL_DRET:    dret   <= csr_wdata;
                    default: ;
                endcase
            end
            if (dbg_entry) begin
                dbg_dst <= 1'b1;
                if (exc_cause == CC_DEBUG) begin
                    dbg_dcl  <= 1'b1;
                    dbg_code <= DBG_BRK_CODE;
                end else begin
                    dbg_dei  <= 1'b1;
                end
                dret     <= core_pc;
                mode_plv <= '0;
                mode_ie  <= 1'b0;
                redir_v  <= 1'b1;
                redir_pc <= dbg_pc;
            end else if (norm_entry) begin
                if (sets_badaddr(ent_cause))           badv <= core_pc;
                if (!skips_badinsn(ent_cause, ent_sub)) badi <= XLEN'(core_insn);
                if (rf_flag) begin
                    rfp_plv <= mode_plv; rfp_ie <= mode_ie;
                    rf_pc   <= core_pc[XLEN-1:2];
                    mode_da <= 1'b1;     mode_pg <= 1'b0;
                end else begin
                    st_ecode <= ent_cause; st_esub <= ent_sub;
                    pm_plv   <= mode_plv;  pm_ie   <= mode_ie;
                    era      <= core_pc;
                end
                mode_plv <= '0;
                mode_ie  <= 1'b0;
                redir_v  <= 1'b1;
                redir_pc <= norm_pc;
            end else if (ertn_valid) begin
                if (rf_flag) begin
                    mode_plv <= rfp_plv; mode_ie <= rfp_ie;
                    redir_pc <= {rf_pc, 2'b00};
                    rf_flag  <= 1'b0;
                end else begin
                    mode_plv <= pm_plv;  mode_ie <= pm_ie;
                    redir_pc <= era;
                end
                redir_v <= 1'b1;
            end
        end
    end

    // Register read mux.
    always_comb begin
        csr_rdata = '0;
        case (csr_rsel)
            SEL_MODE:    csr_rdata[4:0] = {mode_pg, mode_da, mode_ie, mode_plv};
            SEL_PMODE:   csr_rdata[2:0] = {pm_ie, pm_plv};
            SEL_RFPMODE: csr_rdata[2:0] = {rfp_ie, rfp_plv};
            SEL_CFG: begin
                csr_rdata[NUM_IRQ-1:0] = cfg_lie;
                csr_rdata[18:16]       = cfg_vs;
            end
            SEL_STAT: begin
                csr_rdata[NUM_IRQ-1:0] = st_is;
                csr_rdata[21:16]       = st_ecode;
                csr_rdata[30:22]       = st_esub;
            end
            SEL_RET:     csr_rdata = era;
            SEL_BADADDR: csr_rdata = badv;
            SEL_BADINSN: csr_rdata = badi;
            SEL_BASE:    csr_rdata = base;
            SEL_RFBASE:  csr_rdata = rfbase;
            SEL_RFRET:   csr_rdata = {rf_pc, 1'b0, rf_flag};
            SEL_DBG: begin
                csr_rdata[2:0]   = {dbg_dcl, dbg_dei, dbg_dst};
                csr_rdata[21:16] = dbg_code;
            end
            SEL_DRET:    csr_rdata = dret;
            default:     csr_rdata = '0;
        endcase
    end

    assign redirect_valid = redir_v;
    assign redirect_pc    = redir_pc;
    assign cur_plv        = mode_plv;
    assign cur_ie         = mode_ie;

    // Any entry leaves the core at privilege 0 with interrupts off.
    p_entry_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_entry || norm_entry) |=> (cur_plv == 2'd0 && !cur_ie && redirect_valid));

    // A breakpoint or nested interrupt puts the block in debug state.
    p_dbg_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_entry |=> (dbg_dst && redirect_pc == dbg_pc));

    // Refill entries switch to direct addressing with paging off.
    p_refill_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_entry && rf_flag) |=> (mode_da && !mode_pg));

    // In debug state, interrupt lines alone never cause a redirect.
    p_dbg_blocks_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_dst && !exc_valid && !ertn_valid) |=> !redirect_valid);

endmodule

// File: tb/trap_entry_unit_tb.sv
`timescale 1ns/1ps
module trap_entry_unit_tb;
    import trap_pkg::*;

    localparam int NIRQ = 8;
    localparam int EXTB = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 1'b0;
    logic [5:0]  exc_cause = '0;
    logic [8:0]  exc_sub = '0;
    logic [31:0] core_pc = '0, core_insn = '0;
    logic [7:0]  irq_lines = '0;
    logic        ertn_valid = 1'b0;
    logic        csr_we = 1'b0;
    logic [3:0]  csr_wsel = '0, csr_rsel = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata, redirect_pc;
    logic        redirect_valid, cur_ie;
    logic [1:0]  cur_plv;

    always #2.5 clk = ~clk;

    trap_entry_unit u_dut (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
        .exc_sub(exc_sub), .core_pc(core_pc), .core_insn(core_insn),
        .irq_lines(irq_lines), .ertn_valid(ertn_valid), .csr_we(csr_we),
        .csr_wsel(csr_wsel), .csr_wdata(csr_wdata), .csr_rsel(csr_rsel),
        .csr_rdata(csr_rdata), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .cur_plv(cur_plv), .cur_ie(cur_ie)
    );

    int  checks = 0, errors = 0, cycles = 0;
    bit  live = 0, done = 0;

    // Reference model state
    int unsigned m_plv, m_ie, m_da, m_pg, m_pplv, m_pie, m_rplv, m_rie;
    int unsigned m_lie, m_vs, m_is, m_ecode, m_esub, m_rf, m_rfpc;
    int unsigned m_dst, m_dei, m_dcl, m_dcode, m_rv;
    logic [31:0] m_era, m_badv, m_badi, m_base, m_rfbase, m_dret, m_rpc;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] mrd(input int sel);
        case (sel)
            0:  return 32'(m_plv | (m_ie << 2) | (m_da << 3) | (m_pg << 4));
            1:  return 32'(m_pplv | (m_pie << 2));
            2:  return 32'(m_lie | (m_vs << 16));
            3:  return 32'(m_is | (m_ecode << 16) | (m_esub << 22));
            4:  return m_era;
            5:  return m_badv;
            6:  return m_badi;
            7:  return m_base;
            8:  return m_rfbase;
            9:  return 32'((m_rfpc << 2) | m_rf);
            10: return 32'(m_rplv | (m_rie << 2));
            11: return 32'(m_dst | (m_dei << 1) | (m_dcl << 2) | (m_dcode << 16));
            12: return m_dret;
            default: return 32'h0;
        endcase
    endfunction

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        int unsigned pend, vec, cause, sub, sp, o_plv, o_ie, o_rf;
        bit take, dbg, norm, intr;
        logic [31:0] npc, o_era, o_rfret;
        cycles++;
        if (!rst_n) begin
            m_plv = 0; m_ie = 0; m_da = 1; m_pg = 0; m_pplv = 0; m_pie = 0;
            m_rplv = 0; m_rie = 0; m_lie = 0; m_vs = 0; m_is = 0; m_ecode = 0;
            m_esub = 0; m_rf = 0; m_rfpc = 0; m_dst = 0; m_dei = 0; m_dcl = 0;
            m_dcode = 0; m_rv = 0; m_era = 0; m_badv = 0; m_badi = 0; m_base = 0;
            m_rfbase = 0; m_dret = 0; m_rpc = 32'h1C00_0000;
        end else begin
            pend = m_is & m_lie;
            vec = 0;
            for (int i = 0; i < NIRQ; i++) if (pend[i]) vec = i;
            take  = !exc_valid && !ertn_valid && m_ie == 1 && m_dst == 0 && pend != 0;
            dbg   = exc_valid && (exc_cause == CC_DEBUG || (exc_cause == CC_IRQ && m_dst == 1));
            norm  = (exc_valid && !dbg) || take;
            cause = take ? 0 : exc_cause;
            sub   = take ? 0 : exc_sub;
            intr  = (cause == 0);
            sp    = (m_vs == 0) ? 0 : (4 << m_vs);
            if (dbg)       npc = m_base + 32'h480;
            else if (intr) npc = m_base + 32'((EXTB + vec) * sp);
            else if (m_rf) npc = m_rfbase;
            else           npc = m_base + 32'(cause * sp);
            o_plv = m_plv; o_ie = m_ie; o_rf = m_rf; o_era = m_era;
            o_rfret = 32'(m_rfpc << 2);
            m_is = irq_lines;
            m_rv = 0;
            if (csr_we) begin
                case (csr_wsel)
                    0:  begin m_plv = csr_wdata[1:0]; m_ie = csr_wdata[2];
                              m_da = csr_wdata[3]; m_pg = csr_wdata[4]; end
                    1:  begin m_pplv = csr_wdata[1:0]; m_pie = csr_wdata[2]; end
                    2:  begin m_lie = csr_wdata[7:0]; m_vs = csr_wdata[18:16]; end
                    3:  begin m_ecode = csr_wdata[21:16]; m_esub = csr_wdata[30:22]; end
                    4:  m_era = csr_wdata;
                    5:  m_badv = csr_wdata;
                    6:  m_badi = csr_wdata;
                    7:  m_base = csr_wdata;
                    8:  m_rfbase = csr_wdata;
                    9:  begin m_rf = csr_wdata[0]; m_rfpc = csr_wdata[31:2]; end
                    10: begin m_rplv = csr_wdata[1:0]; m_rie = csr_wdata[2]; end
                    11: begin m_dst = csr_wdata[0]; m_dei = csr_wdata[1];
                              m_dcl = csr_wdata[2]; m_dcode = csr_wdata[21:16]; end
                    12: m_dret = csr_wdata;
                    default: ;
                endcase
            end
            if (dbg) begin
                m_dst = 1;
                if (exc_cause == CC_DEBUG) begin m_dcl = 1; m_dcode = 12; end
                else m_dei = 1;
                m_dret = core_pc; m_plv = 0; m_ie = 0; m_rv = 1; m_rpc = npc;
            end else if (norm) begin
                if (cause >= 11 && cause <= 18) m_badv = core_pc;
                if (!(intr || cause == 3 || (cause == 8 && sub == 0))) m_badi = core_insn;
                if (o_rf == 1) begin
                    m_rplv = o_plv; m_rie = o_ie; m_rfpc = core_pc[31:2]; m_da = 1; m_pg = 0;
                end else begin
                    m_ecode = cause; m_esub = sub; m_pplv = o_plv; m_pie = o_ie; m_era = core_pc;
                end
                m_plv = 0; m_ie = 0; m_rv = 1; m_rpc = npc;
            end else if (ertn_valid) begin
                if (o_rf == 1) begin
                    m_plv = m_rplv; m_ie = m_rie; m_rpc = o_rfret; m_rf = 0;
                end else begin
                    m_plv = m_pplv; m_ie = m_pie; m_rpc = o_era;
                end
                m_rv = 1;
            end
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (live && !done) begin
            chk("R5", "redirect_valid", 32'(redirect_valid), 32'(m_rv));
            chk("R5", "redirect_pc", redirect_pc, m_rpc);
            chk("R9", "cur_plv", 32'(cur_plv), 32'(m_plv));
            chk("R9", "cur_ie", 32'(cur_ie), 32'(m_ie));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] s, input logic [31:0] d);
        @(negedge clk); csr_we = 1; csr_wsel = s; csr_wdata = d;
        @(negedge clk); csr_we = 0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [31:0] v);
        csr_rsel = s; #0.5; v = csr_rdata;
    endtask

    task automatic raise(input logic [5:0] c, input logic [8:0] sb,
                         input logic [31:0] pc, input logic [31:0] insn);
        @(negedge clk); exc_valid = 1; exc_cause = c; exc_sub = sb;
        core_pc = pc; core_insn = insn;
        @(negedge clk); exc_valid = 0;
    endtask

    task automatic ret_strobe();
        @(negedge clk); ertn_valid = 1;
        @(negedge clk); ertn_valid = 0;
    endtask

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1;
        live = 1;
        idle(1);
        // R11: reset state
        chk("R11", "reset redirect_pc", redirect_pc, 32'h1C00_0000);
        chk("R11", "reset redirect_valid", 32'(redirect_valid), 0);
        rd(SEL_MODE, v); chk("R11", "reset MODE", v, 32'h08);
        rd(SEL_CFG, v);  chk("R11", "reset CFG", v, 32'h0);

        wr(SEL_BASE, 32'h9000_0000);
        wr(SEL_CFG, (32'd3 << 16) | 32'hFF);
        wr(SEL_MODE, 32'h3);                 // plv 3, interrupts off
        core_pc = 32'h1000;
        irq_lines = 8'h24;
        idle(4);
        rd(SEL_STAT, v); chk("R1", "pending copy", v & 32'hFF, 32'h24);
        chk("R2", "no entry with enable off", redirect_pc, 32'h1C00_0000);

        wr(SEL_MODE, 32'h7);                 // enable: line 5 taken
        idle(1);
        chk("R3", "line 5 vector entry", redirect_pc, 32'h9000_08A0);
        irq_lines = 8'h00;
        rd(SEL_PMODE, v); chk("R6", "saved mode", v, 32'h7);
        rd(SEL_RET, v);   chk("R6", "return address", v, 32'h1000);
        rd(SEL_STAT, v);  chk("R6", "interrupt cause", (v >> 16) & 32'h3F, 32'h0);
        chk("R9", "plv cleared", 32'(cur_plv), 0);

        ret_strobe();
        chk("R12", "return target", redirect_pc, 32'h1000);
        chk("R12", "enable restored", 32'(cur_ie), 1);

        wr(SEL_CFG, (32'd3 << 16));          // mask all lines
        irq_lines = 8'h01;
        idle(4);
        chk("R1", "masked line ignored", redirect_pc, 32'h1000);
        irq_lines = 8'h00;

        raise(CC_SYSCALL, 9'd0, 32'h2000, 32'hDEAD_BEEF);
        chk("R5", "syscall entry", redirect_pc, 32'h9000_0160);
        rd(SEL_BADADDR, v); chk("R10", "bad address on syscall", v, 32'h2000);
        rd(SEL_BADINSN, v); chk("R10", "insn on syscall", v, 32'hDEAD_BEEF);
        rd(SEL_STAT, v);    chk("R6", "syscall cause", (v >> 16) & 32'h3F, 32'd11);

        raise(CC_FETCHPAGE, 9'd0, 32'h3000, 32'h1234_5678);
        chk("R5", "fetch page entry", redirect_pc, 32'h9000_0060);
        rd(SEL_BADINSN, v); chk("R10", "no insn for fetch fault", v, 32'hDEAD_BEEF);
        rd(SEL_BADADDR, v); chk("R10", "no bad address for fetch fault", v, 32'h2000);

        wr(SEL_CFG, (32'd3 << 16) | 32'hFF);
        wr(SEL_MODE, 32'h7);
        irq_lines = 8'h81;
        idle(3);
        chk("R3", "line 7 beats line 0", redirect_pc, 32'h9000_08E0);
        irq_lines = 8'h00;

        wr(SEL_CFG, 32'h0);                  // spacing zero
        raise(CC_BREAK, 9'd0, 32'h2400, 32'h0);
        chk("R4", "zero spacing entry", redirect_pc, 32'h9000_0000);

        wr(SEL_RFBASE, 32'hA000_0000);
        wr(SEL_RFRET, 32'h1);
        wr(SEL_MODE, 32'h6);                 // plv 2, enable on
        raise(CC_LDPAGE, 9'd0, 32'h4004, 32'h55);
        chk("R7", "refill entry", redirect_pc, 32'hA000_0000);
        rd(SEL_RFRET, v);   chk("R7", "refill return", v, 32'h4005);
        rd(SEL_MODE, v);    chk("R7", "refill mode", v, 32'h08);
        rd(SEL_RFPMODE, v); chk("R7", "refill saved mode", v, 32'h6);
        rd(SEL_RET, v);     chk("R7", "normal return untouched", v, 32'h2400);

        ret_strobe();
        chk("R12", "refill return target", redirect_pc, 32'h4004);
        chk("R12", "refill plv restored", 32'(cur_plv), 2);
        rd(SEL_RFRET, v); chk("R12", "refill flag cleared", v & 32'h1, 0);

        raise(CC_DEBUG, 9'd0, 32'h5000, 32'h0);
        chk("R8", "debug entry", redirect_pc, 32'h9000_0480);
        rd(SEL_DBG, v);  chk("R8", "debug flags", v, 32'h000C_0005);
        rd(SEL_DRET, v); chk("R8", "debug return", v, 32'h5000);

        wr(SEL_CFG, 32'hFF);
        wr(SEL_MODE, 32'h7);
        irq_lines = 8'h02;
        idle(4);
        chk("R2", "debug state blocks lines", redirect_pc, 32'h9000_0480);
        irq_lines = 8'h00;

        raise(CC_IRQ, 9'd0, 32'h6000, 32'h0);
        rd(SEL_DBG, v);  chk("R8", "nested interrupt flag", v, 32'h000C_0007);
        rd(SEL_DRET, v); chk("R8", "nested debug return", v, 32'h6000);

        @(negedge clk);                      // write and trap in one cycle
        csr_we = 1; csr_wsel = SEL_MODE; csr_wdata = 32'h13;
        exc_valid = 1; exc_cause = CC_BREAK; exc_sub = 0; core_pc = 32'h7000;
        @(negedge clk);
        csr_we = 0; exc_valid = 0;
        rd(SEL_MODE, v); chk("R13", "trap wins over write", v, 32'h10);

        idle(2);
        for (int s = 0; s < 13; s++) begin
            rd(4'(s), v);
            chk("R13", $sformatf("register %0d", s), v, mrd(s));
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule